// File: doc/BRIEF.md
# Multi-Set Message Interrupt Collector

This block turns inbound message-signalled interrupt writes into one level interrupt. An inbound write has a 64-bit address, a 32-bit data word and a valid strobe. The vectors are split into eight independent sets, and each set has its own programmable 64-bit capture address. When the address of a write equals the capture address of an enabled set, the data word picks one of that set's 32 vectors. The pending bit of that vector is then latched.

Each set has a mask with one bit per vector. The enabled pending bits of a set are ORed, and the result is gated by that set's enable bit. This gives one summary bit per set. Each summary bit sets a sticky top-level status bit. That status bit is cleared by writing 1 to it. The status is ANDed with a top-level enable register, and any resulting bit drives the interrupt output. Software reads and writes all state through a plain 32-bit register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `msi_set_aggregator`

## Requirements
- R1: After reset, every register reads zero and `irq_out` is low.
- R2: For set s (0..7), the low half of the capture address is read/write at offset 0xC00+0x10*s. The high half is read/write at offset 0xC80+4*s.
- R3: A message is valid, its 64-bit address equals set s's capture address, set-enable bit s at offset 0x190 is 1, and its data n is in 0..31. Then bit n of set s's pending register (offset 0xC04+0x10*s) is set and reads 1 on the first read after that clock edge.
- R4: The following messages change no pending bit: an address that matches no capture address, a set whose enable bit is 0, and data of 32 or more.
- R5: Writing 1 to a pending bit clears it. Writing 0 leaves the bit unchanged. A capture in the same cycle as a clear of the same bit leaves the bit set.
- R6: Set s's summary sets top-level status bit 8+s (offset 0x184) one clock after the pending register AND'd with the mask at 0xC08+0x10*s becomes nonzero while the set is enabled. Pending bits that are masked out never set it.
- R7: Writing 1 to a top-level status bit clears it for one cycle. If the set still has enabled pending vectors, the bit is set again on the next clock.
- R8: `irq_out` is high exactly when some top-level status bit 15:8 is 1 and the same bit of the top-level enable register (offset 0x180) is also 1.
- R9: Unmapped offsets read zero. Status bits 27:24 are reserved for legacy lines and read zero. Enable bits 27:24 are storage only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Inbound message strobe |
| msg_addr | input | 64 | Inbound message address |
| msg_data | input | 32 | Inbound message data (vector index) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_out | output | 1 | Aggregated level interrupt |

## Verification
The checks follow these timings:
- A captured message shows in the pending register on the read right after the edge that samples it.
- The top-level status follows one edge later, because the summary feeds a sticky register. `irq_out` tracks that status with no further delay.
- A cleared status bit reads zero just after the clearing edge. It reads one again after the next edge if the set still has enabled pending vectors.

The bench drives inputs on falling edges and reads a little after them. Each expectation is placed on the exact edge count given above.

// File: rtl/msi_set_aggregator.sv
module msi_set_aggregator #(
  parameter int NUM_SETS    = 8,
  parameter int VEC_PER_SET = 32,
  parameter int OFF_W       = 12,
  parameter logic [OFF_W-1:0] SET_BASE   = 12'hC00,
  parameter logic [OFF_W-1:0] SET_STRIDE = 12'h010,
  parameter logic [OFF_W-1:0] HI_BASE    = 12'hC80,
  parameter logic [OFF_W-1:0] HI_STRIDE  = 12'h004,
  parameter logic [OFF_W-1:0] TOP_EN_OFF = 12'h180,
  parameter logic [OFF_W-1:0] TOP_ST_OFF = 12'h184,
  parameter logic [OFF_W-1:0] SET_EN_OFF = 12'h190,
  parameter int SUM_LSB = 8,
  parameter int LEG_LSB = 24,
  parameter int LEG_NUM = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [63:0]      msg_addr,
  input  logic [31:0]      msg_data,
  input  logic             reg_wr,
  input  logic [OFF_W-1:0] reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq_out
);
  localparam int VIDX_W = $clog2(VEC_PER_SET);
  localparam int FLAT_W = NUM_SETS * VEC_PER_SET;

  logic [NUM_SETS-1:0]        set_en, summary, st_sum, en_sum;
  logic [LEG_NUM-1:0]         en_leg;
  logic [NUM_SETS-1:0][31:0]  rd_part;
  logic [FLAT_W-1:0]          pend_flat;

  wire wr_top_st = reg_wr && reg_addr == TOP_ST_OFF;
  wire [NUM_SETS-1:0] st_clr = wr_top_st ? reg_wdata[SUM_LSB +: NUM_SETS] : '0;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    localparam logic [OFF_W-1:0] A_LO = OFF_W'(SET_BASE + s * SET_STRIDE);
    localparam logic [OFF_W-1:0] A_PD = OFF_W'(A_LO + 4);
    localparam logic [OFF_W-1:0] A_MK = OFF_W'(A_LO + 8);
    localparam logic [OFF_W-1:0] A_HI = OFF_W'(HI_BASE + s * HI_STRIDE);

    logic [31:0]            cap_lo, cap_hi;
    logic [VEC_PER_SET-1:0] pend, vmask, hit_vec, clr_vec;
    logic                   hit;

    assign hit = msg_valid && set_en[s] && msg_addr == {cap_hi, cap_lo}
                 && msg_data < VEC_PER_SET;
    assign hit_vec = hit ? (VEC_PER_SET'(1) << msg_data[VIDX_W-1:0]) : '0;
    assign clr_vec = (reg_wr && reg_addr == A_PD) ? reg_wdata[VEC_PER_SET-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_lo <= '0;
        cap_hi <= '0;
        pend   <= '0;
        vmask  <= '0;
      end else begin
        if (reg_wr && reg_addr == A_LO) cap_lo <= reg_wdata;
        if (reg_wr && reg_addr == A_HI) cap_hi <= reg_wdata;
        if (reg_wr && reg_addr == A_MK) vmask  <= reg_wdata[VEC_PER_SET-1:0];
        pend <= (pend & ~clr_vec) | hit_vec;
      end
    end

    assign summary[s] = set_en[s] && |(pend & vmask);
    assign pend_flat[s*VEC_PER_SET +: VEC_PER_SET] = pend;
    assign rd_part[s] = (reg_addr == A_LO) ? cap_lo :
                        (reg_addr == A_HI) ? cap_hi :
                        (reg_addr == A_PD) ? 32'(pend) :
                        (reg_addr == A_MK) ? 32'(vmask) : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_en <= '0;
      en_sum <= '0;
      en_leg <= '0;
      st_sum <= '0;
    end else begin
      if (reg_wr && reg_addr == SET_EN_OFF) set_en <= reg_wdata[NUM_SETS-1:0];
      if (reg_wr && reg_addr == TOP_EN_OFF) begin
        en_sum <= reg_wdata[SUM_LSB +: NUM_SETS];
        en_leg <= reg_wdata[LEG_LSB +: LEG_NUM];
      end
      st_sum <= (st_sum | summary) & ~st_clr;
    end
  end

  assign irq_out = |(st_sum & en_sum);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      TOP_EN_OFF: begin
        reg_rdata[SUM_LSB +: NUM_SETS] = en_sum;
        reg_rdata[LEG_LSB +: LEG_NUM]  = en_leg;
      end
      TOP_ST_OFF: reg_rdata[SUM_LSB +: NUM_SETS] = st_sum;
      SET_EN_OFF: reg_rdata[NUM_SETS-1:0]        = set_en;
      default: ;
    endcase
    for (int s = 0; s < NUM_SETS; s++) reg_rdata = reg_rdata | rd_part[s];
  end
endmodule

// File: rtl/msi_set_aggregator_chk.sv
module msi_set_aggregator_chk #(
  parameter int NB = 256,
  parameter int NS = 8,
  parameter logic [11:0] PEND0_OFF = 12'hC04
) (
  input logic          clk,
  input logic          rst_n,
  input logic          msg_valid,
  input logic          reg_wr,
  input logic [11:0]   reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [NB-1:0] pend_flat,
  input logic [NS-1:0] summary,
  input logic [NS-1:0] st_sum,
  input logic          irq_out
);
  // R4
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(pend_flat & ~$past(pend_flat)) |-> $past(msg_valid));

  // R5
  pend_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == PEND0_OFF && !msg_valid)
      |=> ((pend_flat[31:0] & $past(reg_wdata)) == 32'h0));

  // R7
  st_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(st_sum & ~$past(st_sum)) |-> $past(|summary));

  // R1
  irq_reset_chk: assert property (@(posedge clk)
    !rst_n |=> !irq_out);
endmodule

bind msi_set_aggregator msi_set_aggregator_chk #(
  .NB(NUM_SETS * VEC_PER_SET), .NS(NUM_SETS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pend_flat(pend_flat),
  .summary(summary), .st_sum(st_sum), .irq_out(irq_out)
);

// File: tb/msi_set_aggregator_test.sv
module msi_set_aggregator_test;
  logic        clk = 0, rst_n = 0;
  logic        msg_valid = 0, reg_wr = 0;
  logic [63:0] msg_addr = '0;
  logic [31:0] msg_data = '0, reg_wdata = '0, reg_rdata;
  logic [11:0] reg_addr = '0;
  logic        irq_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  msi_set_aggregator uut (.*);

  // {addr[63:0], data[31:0], set[2:0], bit[4:0], hit}
  localparam logic [104:0] TBL [0:7] = '{
    {64'h000000A0_FE000000, 32'd0,  3'd0, 5'd0,  1'b1},
    {64'h000000A3_FE0000C0, 32'd31, 3'd3, 5'd31, 1'b1},
    {64'h000000A5_FE000140, 32'd17, 3'd5, 5'd17, 1'b1},
    {64'h000000B2_FE000080, 32'd2,  3'd2, 5'd2,  1'b0},
    {64'h000000A7_FE0001C0, 32'd4,  3'd7, 5'd4,  1'b0},
    {64'h000000A1_FE000040, 32'd32, 3'd1, 5'd0,  1'b0},
    {64'h000000A6_FE000180, 32'd9,  3'd6, 5'd9,  1'b1},
    {64'h000000A4_FE000104, 32'd3,  3'd4, 5'd3,  1'b0}
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic msg(logic [63:0] a, logic [31:0] d);
    @(negedge clk); msg_valid = 1; msg_addr = a; msg_data = d;
    @(negedge clk); msg_valid = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(12'h184, v); chk("R1 status", v, 0);
    rd(12'h180, v); chk("R1 enable", v, 0);
    rd(12'h190, v); chk("R1 set enable", v, 0);
    rd(12'hC34, v); chk("R1 pending", v, 0);
    chk("R1 irq", {31'd0, irq_out}, 0);

    for (int s = 0; s < 8; s++) begin
      wr(12'hC00 + 12'(s * 16), 32'hFE000000 + 32'(s * 64));
      wr(12'hC80 + 12'(s * 4), 32'hA0 + 32'(s));
      wr(12'hC08 + 12'(s * 16), 32'hFFFFFFFF);
    end
    wr(12'h190, 32'h7F);
    // R2 readback
    rd(12'hC30, v); chk("R2 low half", v, 32'hFE0000C0);
    rd(12'hC8C, v); chk("R2 high half", v, 32'hA3);
    // R9 unmapped and reserved
    rd(12'h188, v); chk("R9 unmapped", v, 0);
    rd(12'hC0C, v); chk("R9 unmapped in set", v, 0);
    wr(12'h180, 32'h0F000000);
    rd(12'h180, v); chk("R9 legacy enable store", v, 32'h0F000000);
    wr(12'h180, 32'h0);

    // R3 / R4 vector table
    for (int i = 0; i < 8; i++) begin
      logic [104:0] e;
      logic [11:0] pa;
      e = TBL[i];
      pa = 12'hC04 + 12'(e[8:6]) * 12'h10;
      wr(pa, 32'hFFFFFFFF);
      msg(e[104:41], e[40:9]);
      rd(pa, v);
      chk(e[0] ? "R3 capture" : "R4 drop", v, e[0] ? (32'h1 << e[5:1]) : 32'h0);
    end

    for (int s = 0; s < 8; s++) wr(12'hC04 + 12'(s * 16), 32'hFFFFFFFF);
    wr(12'h184, 32'hFFFFFFFF);
    rd(12'h184, v); chk("R7 all cleared", v, 0);

    // R5 write-one-to-clear
    msg(64'h000000A0_FE000000, 32'd0);
    msg(64'h000000A0_FE000000, 32'd5);
    wr(12'hC04, 32'h1);
    rd(12'hC04, v); chk("R5 clear one", v, 32'h20);
    wr(12'hC04, 32'h0);
    rd(12'hC04, v); chk("R5 zero no effect", v, 32'h20);
    @(negedge clk);
    reg_wr = 1; reg_addr = 12'hC04; reg_wdata = 32'h20;
    msg_valid = 1; msg_addr = 64'h000000A0_FE000000; msg_data = 32'd5;
    @(negedge clk); reg_wr = 0; msg_valid = 0;
    rd(12'hC04, v); chk("R5 capture beats clear", v, 32'h20);
    wr(12'hC04, 32'hFFFFFFFF);
    wr(12'h184, 32'hFFFFFFFF);

    // R6 masking
    wr(12'hC28, 32'h8);
    msg(64'h000000A2_FE000080, 32'd4);
    @(negedge clk);
    rd(12'hC24, v); chk("R6 masked pending latched", v, 32'h10);
    rd(12'h184, v); chk("R6 masked no summary", v, 0);
    msg(64'h000000A2_FE000080, 32'd3);
    rd(12'h184, v); chk("R6 summary not yet", v, 0);
    @(negedge clk);
    rd(12'h184, v); chk("R6 summary set", v, 32'h400);
    chk("R8 irq off when disabled", {31'd0, irq_out}, 0);
    wr(12'h180, 32'h400);
    #1 chk("R8 irq on", {31'd0, irq_out}, 1);
    // R7 re-assert
    wr(12'h184, 32'h400);
    rd(12'h184, v); chk("R7 cleared cycle", v, 0);
    chk("R8 irq drops", {31'd0, irq_out}, 0);
    @(negedge clk);
    rd(12'h184, v); chk("R7 re-asserted", v, 32'h400);
    chk("R8 irq back", {31'd0, irq_out}, 1);
    wr(12'hC24, 32'h8);
    wr(12'h184, 32'h400);
    @(negedge clk);
    rd(12'h184, v); chk("R7 stays clear", v, 0);
    chk("R8 irq low", {31'd0, irq_out}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule